// File: doc/BRIEF.md
# Packed unit condition evaluator

This block produces the single-bit unit condition for a packed add or subtract result. It takes the two operands, the result that the datapath already produced, a 4-bit condition field and a doubleword select. From these it decides one of two things. The first is whether any byte or halfword lane of the result is zero. The second is whether any nibble, byte or halfword lane produced a carry-out.

The zero tests use the subtract-and-mask trick over a whole word. The carry tests mask a per-bit carry-out vector that is rebuilt from the operands and the result. The low bit of the condition field inverts the outcome. With the doubleword select clear, only the low 32 bits take part. With it set, every lane of the 64-bit word counts.

Inputs are captured when `in_valid` is high. The condition appears on the next clock, with `out_valid` high for that cycle. The adder, instruction decode, nullification and any trap on the condition are handled elsewhere.

Top module: `unit_cond_eval`

## Requirements
- R1: While `rst_n` is low, and on the first sampling after reset, `out_valid` and `cond` are 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `cond` keeps its value in cycles with no capture.
- R3: With `cf[3:1]` = 2, the condition is true when some byte of the evaluated result is 0x00.
- R4: With `cf[3:1]` = 3, the condition is true when some 16-bit halfword of the evaluated result is zero.
- R5: With `cf[3:1]` = 4, the condition is true when some nibble produced a carry-out. Bit i of the carry vector is `(a&b | (a|b)&~res)[i]`, and for a true sum this equals the carry out of bit i. The bit examined is bit 3 of each nibble.
- R6: With `cf[3:1]` = 6, the condition is true when the carry out of bit 7 of some byte is set.
- R7: With `cf[3:1]` = 7, the condition is true when the carry out of bit 15 of some halfword is set.
- R8: With `cf[3:1]` equal to 0, 1 or 5, the condition is false before any inversion.
- R9: `cf[0]` = 1 inverts the selected condition, including the constant-false codes.
- R10: With `dword` = 0, bits 63:32 of all inputs have no effect. With `dword` = 1, lanes in the upper half count the same as lanes in the lower half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for the inputs |
| cf | input | 4 | Condition field: [3:1] is the code, [0] inverts |
| dword | input | 1 | 1 evaluates 64 bits, 0 evaluates the low 32 bits |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| res | input | W | Result of the packed operation |
| out_valid | output | 1 | Condition valid, one cycle after capture |
| cond | output | 1 | Registered condition bit |

## Verification
Every evaluation is a single capture, so a wrong lane mask or a wrong constant shows up on `cond` in the very next cycle for the affected code. The harder cases are masks that are wrong only in the upper half, or only in one lane position. The sweep therefore places lone zero lanes and lone carries in each lane of both halves, under both settings of `dword`. A stale capture register would show as `cond` changing in a cycle with no strobe. That is observed one cycle after each evaluation.

// File: rtl/unit_cond_eval.sv
module unit_cond_eval #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   cf,
  input  logic         dword,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] res,
  output logic         out_valid,
  output logic         cond
);
  localparam int unsigned HW = W / 2;
  localparam logic [W-1:0] ONE_B  = {(W/8){8'h01}};
  localparam logic [W-1:0] TOP_B  = {(W/8){8'h80}};
  localparam logic [W-1:0] ONE_H  = {(W/16){16'h0001}};
  localparam logic [W-1:0] TOP_H  = {(W/16){16'h8000}};
  localparam logic [W-1:0] TOP_N  = {(W/4){4'h8}};

  logic [W-1:0] span, cvec, zb, zh;
  logic         hit;

  assign span = dword ? '1 : {{HW{1'b0}}, {HW{1'b1}}};
  assign cvec = cf[3] ? ((opa & opb) | ((opa | opb) & ~res)) : '0;
  assign zb   = (res - ONE_B) & ~res & TOP_B & span;
  assign zh   = (res - ONE_H) & ~res & TOP_H & span;

  always_comb begin
    case (cf[3:1])
      3'd2:    hit = |zb;
      3'd3:    hit = |zh;
      3'd4:    hit = |(cvec & TOP_N & span);
      3'd6:    hit = |(cvec & TOP_B & span);
      3'd7:    hit = |(cvec & TOP_H & span);
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cond      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) cond <= hit ^ cf[0];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !out_valid && !cond);

  // R2
  hold_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cond));

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8 R9
  const_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (cf[3:1] == 3'd0 || cf[3:1] == 3'd1 || cf[3:1] == 3'd5)
    |=> cond == $past(cf[0]));

  // R3
  zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cf[3:1] == 3'd2 && res[31:0] == 32'd0 |=> cond == !$past(cf[0]));

  // R6
  no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cf[3:1] == 3'd6 && (opa | opb) == '0 |=> cond == $past(cf[0]));
endmodule

// File: tb/test_unit_cond_eval.sv
`timescale 1ns/1ps
module test_unit_cond_eval;
  localparam int unsigned W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   cf = '0;
  logic         dword = 1'b0;
  logic [W-1:0] opa = '0, opb = '0, res = '0;
  logic         out_valid, cond;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  unit_cond_eval #(.W(W)) i_unit_cond_eval (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cf(cf), .dword(dword),
    .opa(opa), .opb(opb), .res(res), .out_valid(out_valid), .cond(cond)
  );

  function automatic bit carry_at(logic [W-1:0] a, logic [W-1:0] b, int i);
    logic [W:0] m, s;
    m = ({{W{1'b0}}, 1'b1} << (i + 1)) - 1;
    s = ({1'b0, a} & m) + ({1'b0, b} & m);
    return s[i+1];
  endfunction

  function automatic bit ref_cond(logic [3:0] c, bit dw, logic [W-1:0] a,
                                  logic [W-1:0] b, logic [W-1:0] r);
    int n = dw ? 64 : 32;
    int lw;
    bit h = 0;
    case (c[3:1])
      3'd2: for (int k = 0; k < n / 8; k++) if (r[8*k +: 8] == 8'd0) h = 1;
      3'd3: for (int k = 0; k < n / 16; k++) if (r[16*k +: 16] == 16'd0) h = 1;
      3'd4, 3'd6, 3'd7: begin
        lw = (c[3:1] == 3'd4) ? 4 : (c[3:1] == 3'd6) ? 8 : 16;
        for (int k = 0; k < n / lw; k++) if (carry_at(a, b, k*lw + lw - 1)) h = 1;
      end
      default: h = 0;
    endcase
    return h ^ c[0];
  endfunction

  function automatic string tag(logic [3:0] c);
    case (c[3:1])
      3'd2: return c[0] ? "R3/R9" : "R3";
      3'd3: return c[0] ? "R4/R9" : "R4";
      3'd4: return c[0] ? "R5/R9" : "R5";
      3'd6: return c[0] ? "R6/R9" : "R6";
      3'd7: return c[0] ? "R7/R9" : "R7";
      default: return c[0] ? "R8/R9" : "R8";
    endcase
  endfunction

  task automatic check(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b (cf=%h dword=%0b a=%h b=%h r=%h)",
               req, got, exp, cf, dword, opa, opb, res);
    end
  endtask

  task automatic run(logic [3:0] c, bit dw, logic [W-1:0] a, logic [W-1:0] r, string req);
    logic e;
    logic [W-1:0] b;
    b = r - a;
    e = ref_cond(c, dw, a, b, r);
    @(negedge clk);
    cf = c; dword = dw; opa = a; opb = b; res = r; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", out_valid, 1'b1);
    check(req.len() > 0 ? req : tag(c), cond, e);
    cf = ~c; opa = ~a; res = ~r;
    @(negedge clk);
    check("R2", out_valid, 1'b0);
    check("R2", cond, e);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pats [0:15];
    logic [W-1:0] avals [0:3];
    pats[0]  = '0;
    pats[1]  = '1;
    pats[2]  = 64'h1111_1111_1111_1100;
    pats[3]  = 64'h1111_1111_1100_1111;
    pats[4]  = 64'h1111_1111_0000_1111;
    pats[5]  = 64'h1100_1111_1111_1111;
    pats[6]  = 64'h0000_1111_1111_1111;
    pats[7]  = 64'h0101_0101_0101_0101;
    pats[8]  = 64'h8080_8080_8080_8080;
    pats[9]  = 64'h0100_0001_0100_0001;
    pats[10] = 64'h00FF_FF00_FFFF_FFFF;
    pats[11] = 64'h1234_5678_9ABC_DEF0;
    pats[12] = 64'hFFFF_FFFF_0000_0000;
    pats[13] = 64'h0000_0000_FFFF_FFFF;
    pats[14] = 64'h7F7F_7F7F_7F7F_7F7F;
    pats[15] = 64'h8000_8000_8000_8000;
    avals[0] = '0;
    avals[1] = 64'h0F0F_0F0F_0F0F_0F0F;
    avals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    avals[3] = 64'h8888_8888_8888_8888;

    repeat (3) @(negedge clk);
    check("R1", out_valid, 1'b0);
    check("R1", cond, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", out_valid, 1'b0);
    check("R1", cond, 1'b0);

    for (int c = 0; c < 16; c++)
      for (int dw = 0; dw < 2; dw++)
        for (int p = 0; p < 16; p++)
          for (int q = 0; q < 4; q++)
            run(c[3:0], dw[0], avals[q], pats[p], "");

    for (int n = 0; n < 600; n++) begin
      logic [W-1:0] a, r;
      a = {$urandom(), $urandom()};
      r = {$urandom(), $urandom()};
      if (n % 3 == 0) r[8*(n%8) +: 8] = 8'd0;
      run(4'(n % 16), n[4], a, r, "");
    end

    // R10: only the upper half has zero lanes or carries
    run(4'h4, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_1111_1111, "R10");
    run(4'h4, 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_1111_1111, "R10");
    run(4'hC, 1'b0, 64'hFF00_0000_0000_0000, 64'hFE00_0000_0000_0000, "R10");
    run(4'hC, 1'b1, 64'hFF00_0000_0000_0000, 64'hFE00_0000_0000_0000, "R10");
    run(4'hE, 1'b0, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0002, "R10");
    run(4'hE, 1'b1, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0002, "R10");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule